// File: doc/BRIEF.md
# L3 Three-Wire Control Bus Master

This block is the initiator side of a three-wire serial control link (clock, mode, data) used to set up an audio codec. A client hands over one request at a time: a 6-bit device address, a 2-bit register-type code, a direction, and one or two data bytes. The block turns that request into the bit-level waveform. It drives the address byte with the mode line low and the data bytes with the mode line high. Every interval on the wire (clock low time, clock high time, mode setup, mode hold, and the halt pulse ahead of a second data byte) is a parameter counted in system clocks.

For writes the data line is driven for the whole transaction. For reads the block releases the data line once the address byte and its hold time are over. It then samples the line once per bit, presents each received byte on a byte-wide output with a one-cycle strobe, and marks the end of the transaction with a done pulse. A new request is taken only while the block is idle.

Top module: `l3_master`

## Requirements
- R1: `req_ready_o` is high only while idle; a request is taken on a cycle with `req_valid_i` and `req_ready_o` both high, and `req_valid_i` raised during a transaction has no effect on the waveform or on the number of done pulses.
- R2: After reset and between transactions the bus idles with `l3_clk_o`=1, `l3_mode_o`=1, `l3_data_oe_o`=0 and `l3_data_o`=1.
- R3: In the first cycle after a request is taken, clock, mode and data are all driven high (`l3_data_oe_o`=1) for exactly one cycle.
- R4: The address byte is {`req_dev_i`, `req_type_i`}, with the type code in bits 1:0. It is sent with mode low and least significant bit first. The clock falls together with mode, so the first low interval lasts SETUP_CYC+LOW_CYC cycles.
- R5: Each bit holds the clock low for LOW_CYC cycles and then high for HIGH_CYC cycles. Driven data changes only while the clock is low, and a bit is valid at its rising clock edge.
- R6: Data bytes are sent with mode high and least significant bit first. The first data byte follows the address with no extra clock pulse: the clock stays high for HIGH_CYC+HOLD_CYC+SETUP_CYC cycles between the last address bit and the first data bit.
- R7: When `req_two_i`=1, the first data byte (`req_wdata_i[7:0]`) is followed by a halt pulse before the second byte (`req_wdata_i[15:8]`). The sequence is clock high for HIGH_CYC+HOLD_CYC, then low for HALT_CYC, then high for SETUP_CYC, and then the first bit of the second byte.
- R8: On a read (`req_read_i`=1), `l3_data_oe_o` is 0 throughout the data bytes. `l3_data_i` is sampled in the last cycle of each clock-low interval, and the i-th sampled bit becomes bit i of the byte.
- R9: Each received byte appears on `rdata_o` with a one-cycle `rdata_valid_o` at the end of its hold interval. `done_o` pulses for one cycle at the end of every transaction, in the same cycle as the strobe for the last read byte, and the bus returns to the R2 idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_two_i | input | 1 | 1 = two data bytes, 0 = one |
| req_dev_i | input | 6 | Device address, upper six bits of the address byte |
| req_type_i | input | 2 | Register-type code, lower two bits of the address byte |
| req_wdata_i | input | 16 | Write bytes: [7:0] first, [15:8] second |
| rdata_o | output | 8 | Last received read byte |
| rdata_valid_o | output | 1 | One-cycle strobe per received byte |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| l3_clk_o | output | 1 | Bus clock |
| l3_mode_o | output | 1 | Bus mode: 0 address phase, 1 data phase |
| l3_data_o | output | 1 | Bus data, driven value |
| l3_data_oe_o | output | 1 | Bus data output enable |
| l3_data_i | input | 1 | Bus data, sampled value |

## Verification
Two events coincide at the end of a read: the strobe for the final received byte and the done pulse come out in the same cycle. For a two-byte read, the reload of the shift register for the second byte also falls in the same cycle as the strobe for the first byte. Both cases are provoked with one-byte and two-byte reads against a bench target that drives a known pattern on each falling clock edge of the data phase. The bench judges them by checking that every strobed byte matches the pattern and that the single done pulse lands together with the last strobe. A second overlap, a request raised while a transaction is in progress, is driven for several cycles during a two-byte write and judged by a waveform that stays intact and a done count of one.

// File: rtl/l3_pkg.sv
package l3_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SETUP,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_HOLD,
    ST_HALT
  } l3_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_DATA0,
    PH_DATA1
  } l3_phase_e;

endpackage

// File: rtl/l3_timer.sv
module l3_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R5
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/l3_shreg.sv
module l3_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         rx_i,
  output logic         tx_o,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sh_q;

  // rx enters at the top so the first sampled bit ends in bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (load_i)   sh_q <= load_val_i;
    else if (shift_i)  sh_q <= {rx_i, sh_q[W-1:1]};
  end

  assign tx_o = sh_q[0];
  assign q_o  = sh_q;

  // R8
  sh_lsb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (sh_q[W-2:0] == $past(sh_q[W-1:1])));

endmodule

// File: rtl/l3_master.sv
module l3_master
  import l3_pkg::*;
#(
  parameter int unsigned LOW_CYC   = 3,
  parameter int unsigned HIGH_CYC  = 4,
  parameter int unsigned HALT_CYC  = 6,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned DEV_W     = 6,
  parameter int unsigned TYPE_W    = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_read_i,
  input  logic                   req_two_i,
  input  logic [DEV_W-1:0]       req_dev_i,
  input  logic [TYPE_W-1:0]      req_type_i,
  input  logic [2*(DEV_W+TYPE_W)-1:0] req_wdata_i,
  output logic [DEV_W+TYPE_W-1:0] rdata_o,
  output logic                   rdata_valid_o,
  output logic                   done_o,
  output logic                   l3_clk_o,
  output logic                   l3_mode_o,
  output logic                   l3_data_o,
  output logic                   l3_data_oe_o,
  input  logic                   l3_data_i
);

  localparam int unsigned BYTE_W = DEV_W + TYPE_W;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);
  localparam int unsigned M1 = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int unsigned M2 = (HALT_CYC > M1) ? HALT_CYC : M1;
  localparam int unsigned M3 = (SETUP_CYC > M2) ? SETUP_CYC : M2;
  localparam int unsigned MAXC = (HOLD_CYC > M3) ? HOLD_CYC : M3;
  localparam int unsigned CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  l3_state_e state_q, state_d;
  l3_phase_e phase_q, phase_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic rd_q, rd_d, two_q, two_d;
  logic [2*BYTE_W-1:0] wdata_q, wdata_d;
  logic clk_q, clk_d, mode_q, mode_d, data_q, data_d, oe_q, oe_d;
  logic rvalid_q, rvalid_d, done_q, done_d;
  logic [BYTE_W-1:0] rdata_q;

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_tx;
  logic [BYTE_W-1:0] sh_val, sh_q;

  l3_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  l3_shreg #(.W(BYTE_W)) u_shreg (
    .clk_i, .rst_ni, .load_i(sh_load), .load_val_i(sh_val), .shift_i(sh_shift),
    .rx_i(l3_data_i), .tx_o(sh_tx), .q_o(sh_q)
  );

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bit_d    = bit_q;
    rd_d     = rd_q;
    two_d    = two_q;
    wdata_d  = wdata_q;
    clk_d    = clk_q;
    mode_d   = mode_q;
    data_d   = data_q;
    oe_d     = oe_q;
    rvalid_d = 1'b0;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_val   = '0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d  = ST_START;
        phase_d  = PH_ADDR;
        rd_d     = req_read_i;
        two_d    = req_two_i;
        wdata_d  = req_wdata_i;
        {clk_d, mode_d, data_d, oe_d} = 4'b1111;
        tmr_load = 1'b1;
        sh_load  = 1'b1;
        sh_val   = {req_dev_i, req_type_i};
      end
      ST_START: if (tmr_zero) begin
        state_d  = ST_SETUP;
        clk_d    = 1'b0;
        mode_d   = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_zero) begin
        state_d  = ST_BIT_LO;
        clk_d    = 1'b0;
        data_d   = sh_tx;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(LOW_CYC - 1);
      end
      ST_BIT_LO: if (tmr_zero) begin
        state_d  = ST_BIT_HI;
        clk_d    = 1'b1;
        sh_shift = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HIGH_CYC - 1);
      end
      ST_BIT_HI: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (bit_q == BIT_W'(BYTE_W - 1)) begin
          state_d = ST_HOLD;
          bit_d   = '0;
          tmr_val = CNT_W'(HOLD_CYC - 1);
        end else begin
          state_d = ST_BIT_LO;
          bit_d   = bit_q + BIT_W'(1);
          clk_d   = 1'b0;
          data_d  = sh_tx;
          tmr_val = CNT_W'(LOW_CYC - 1);
        end
      end
      ST_HOLD: if (tmr_zero) begin
        if (phase_q == PH_ADDR) begin
          state_d  = ST_SETUP;
          phase_d  = PH_DATA0;
          mode_d   = 1'b1;
          oe_d     = !rd_q;
          sh_load  = 1'b1;
          sh_val   = wdata_q[BYTE_W-1:0];
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETUP_CYC - 1);
        end else begin
          rvalid_d = rd_q;
          if (phase_q == PH_DATA0 && two_q) begin
            state_d  = ST_HALT;
            phase_d  = PH_DATA1;
            clk_d    = 1'b0;
            sh_load  = 1'b1;
            sh_val   = wdata_q[2*BYTE_W-1:BYTE_W];
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HALT_CYC - 1);
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            {clk_d, mode_d, data_d, oe_d} = 4'b1110;
          end
        end
      end
      ST_HALT: if (tmr_zero) begin
        state_d  = ST_SETUP;
        clk_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SETUP_CYC - 1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR;
      bit_q    <= '0;
      rd_q     <= 1'b0;
      two_q    <= 1'b0;
      wdata_q  <= '0;
      {clk_q, mode_q, data_q, oe_q} <= 4'b1110;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      bit_q    <= bit_d;
      rd_q     <= rd_d;
      two_q    <= two_d;
      wdata_q  <= wdata_d;
      clk_q    <= clk_d;
      mode_q   <= mode_d;
      data_q   <= data_d;
      oe_q     <= oe_d;
      rvalid_q <= rvalid_d;
      done_q   <= done_d;
      if (rvalid_d) rdata_q <= sh_q;
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
  assign done_o        = done_q;
  assign l3_clk_o      = clk_q;
  assign l3_mode_o     = mode_q;
  assign l3_data_o     = data_q;
  assign l3_data_oe_o  = oe_q;

  // R1
  accept_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_ready_o) |-> $past(req_valid_i));

  // R5
  data_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l3_data_oe_o && $past(l3_data_oe_o) && !$stable(l3_data_o)) |-> !l3_clk_o);

  // R4
  addr_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l3_mode_o |-> l3_data_oe_o);

  // R8
  rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> (!l3_data_oe_o && l3_mode_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

endmodule

// File: tb/tb_l3_master.sv
module tb_l3_master;

  localparam int LOW = 3, HIGH = 4, HALT = 6, SETUP = 2, HOLD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, req_two = 1'b0;
  logic [5:0] req_dev = '0;
  logic [1:0] req_type = '0;
  logic [15:0] req_wdata = '0;
  logic l3_data_in = 1'b0;
  logic req_ready, rdata_valid, done, l3_clk, l3_mode, l3_data, l3_oe;
  logic [7:0] rdata;

  always #10 clk = ~clk;

  l3_master #(.LOW_CYC(LOW), .HIGH_CYC(HIGH), .HALT_CYC(HALT),
              .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_read_i(req_read), .req_two_i(req_two), .req_dev_i(req_dev),
    .req_type_i(req_type), .req_wdata_i(req_wdata), .rdata_o(rdata),
    .rdata_valid_o(rdata_valid), .done_o(done), .l3_clk_o(l3_clk),
    .l3_mode_o(l3_mode), .l3_data_o(l3_data), .l3_data_oe_o(l3_oe),
    .l3_data_i(l3_data_in)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bus monitor and read target, all at the falling system edge
  int lo_run[64], hi_run[64], nlo, nhi, run, nr, nfall, nrd, ndone;
  logic prev;
  logic r_mode[64], r_data[64], r_oe[64];
  logic [7:0] rd_got[4];
  logic [15:0] rd_pat;
  logic done_with_valid;

  task automatic mon_clear();
    nlo = 0; nhi = 0; run = 0; nr = 0; nfall = 0; nrd = 0; ndone = 0;
    prev = 1'b1; done_with_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (l3_clk == prev) run++;
      else begin
        if (prev == 1'b0) begin
          if (nlo < 64) lo_run[nlo] = run;
          nlo++;
          if (nr < 64) begin r_mode[nr] = l3_mode; r_data[nr] = l3_data; r_oe[nr] = l3_oe; end
          nr++;
        end else begin
          if (nhi < 64) hi_run[nhi] = run;
          nhi++;
          if (l3_mode) begin
            if (nfall < 8) l3_data_in = rd_pat[nfall];
            else if (nfall > 8 && nfall < 17) l3_data_in = rd_pat[nfall - 1];
            else l3_data_in = 1'b0;
            nfall++;
          end
        end
        run = 1;
      end
      prev = l3_clk;
      if (rdata_valid) begin
        if (nrd < 4) rd_got[nrd] = rdata;
        nrd++;
      end
      if (done) begin
        ndone++;
        done_with_valid = rdata_valid;
      end
    end
  end

  function automatic logic [7:0] rise_byte(input int base);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = r_data[base + i];
    return b;
  endfunction

  task automatic xact(input bit rd, input bit two, input logic [5:0] dev,
                      input logic [1:0] typ, input logic [15:0] wd,
                      input logic [15:0] pat, input bit inject, input bit timing);
    int n;
    int exp_rises;
    logic mode_ok, oe_ok;
    mon_clear();
    rd_pat = pat;
    @(negedge clk);
    req_read = rd; req_two = two; req_dev = dev; req_type = typ; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R3: one cycle with all three lines driven high
    chk(l3_oe && l3_clk && l3_mode && l3_data, "R3", "start all high",
        {l3_oe, l3_clk, l3_mode, l3_data}, 15);
    chk(!req_ready, "R1", "ready low when busy", req_ready, 0);
    @(negedge clk);
    chk(!l3_clk && !l3_mode, "R4", "addr phase clk/mode low", {l3_clk, l3_mode}, 0);
    if (inject) begin
      for (int k = 0; k < 5; k++) begin
        req_valid = 1'b1; req_read = ~rd; req_dev = ~dev; req_wdata = ~wd;
        @(negedge clk);
        chk(!req_ready, "R1", "ready while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, "R9", "done seen", done, 1);
    @(negedge clk);
    // R2 / R9: back to idle after done
    chk(req_ready && l3_clk && l3_mode && l3_data && !l3_oe, "R2", "idle after done",
        {req_ready, l3_clk, l3_mode, l3_data, l3_oe}, 5'b11110);
    repeat (3) @(negedge clk);
    chk(ndone == 1, "R9", "done pulse count", ndone, 1);
    exp_rises = two ? 25 : 16;
    chk(nr == exp_rises, "R6", "rising edge count", nr, exp_rises);
    if (nr == exp_rises) begin
      mode_ok = 1'b1;
      for (int i = 0; i < 8; i++) if (r_mode[i] !== 1'b0) mode_ok = 1'b0;
      for (int i = 8; i < exp_rises; i++) if (r_mode[i] !== 1'b1) mode_ok = 1'b0;
      chk(mode_ok, "R6", "mode low in address, high in data", mode_ok, 1);
      chk(rise_byte(0) == {dev, typ}, "R4", "address byte lsb first",
          rise_byte(0), {dev, typ});
      if (!rd) begin
        chk(rise_byte(8) == wd[7:0], "R6", "first data byte", rise_byte(8), wd[7:0]);
        if (two)
          chk(rise_byte(17) == wd[15:8], "R7", "second data byte",
              rise_byte(17), wd[15:8]);
      end else begin
        oe_ok = 1'b1;
        for (int i = 8; i < exp_rises; i++) if (r_oe[i] !== 1'b0) oe_ok = 1'b0;
        chk(oe_ok, "R8", "data released during read", oe_ok, 1);
        chk(nrd == (two ? 2 : 1), "R9", "read strobe count", nrd, two ? 2 : 1);
        chk(rd_got[0] == pat[7:0], "R8", "read byte 0", rd_got[0], pat[7:0]);
        if (two) chk(rd_got[1] == pat[15:8], "R8", "read byte 1", rd_got[1], pat[15:8]);
        chk(done_with_valid, "R9", "done with last strobe", done_with_valid, 1);
      end
    end
    if (timing && two && nlo > 17 && nhi > 17) begin
      chk(lo_run[0] == SETUP + LOW, "R4", "first address low", lo_run[0], SETUP + LOW);
      chk(lo_run[3] == LOW, "R5", "bit low time", lo_run[3], LOW);
      chk(hi_run[3] == HIGH, "R5", "bit high time", hi_run[3], HIGH);
      chk(hi_run[8] == HIGH + HOLD + SETUP, "R6", "addr-to-data gap",
          hi_run[8], HIGH + HOLD + SETUP);
      chk(hi_run[16] == HIGH + HOLD, "R7", "high before halt", hi_run[16], HIGH + HOLD);
      chk(lo_run[16] == HALT, "R7", "halt low time", lo_run[16], HALT);
      chk(hi_run[17] == SETUP, "R7", "high after halt", hi_run[17], SETUP);
    end
  endtask

  task automatic reset_check();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2
    chk(req_ready && l3_clk && l3_mode && l3_data && !l3_oe && !done && !rdata_valid,
        "R2", "reset state",
        {req_ready, l3_clk, l3_mode, l3_data, l3_oe, done, rdata_valid}, 7'b1111000);
  endtask

  initial begin
    mon_clear();
    rd_pat = '0;
    reset_check();
    xact(1'b0, 1'b0, 6'h05, 2'b10, 16'h00A7, 16'h0, 1'b0, 1'b0);   // one-byte write
    xact(1'b0, 1'b1, 6'h2A, 2'b01, 16'h3CD2, 16'h0, 1'b0, 1'b1);   // two-byte write, timing
    xact(1'b1, 1'b0, 6'h11, 2'b11, 16'h0, 16'h0059, 1'b0, 1'b0);   // one-byte read
    xact(1'b1, 1'b1, 6'h3F, 2'b00, 16'h0, 16'hE681, 1'b0, 1'b0);   // two-byte read
    xact(1'b0, 1'b1, 6'h16, 2'b01, 16'h5A0F, 16'h0, 1'b1, 1'b0);   // R1 busy requests
    xact(1'b1, 1'b0, 6'h00, 2'b00, 16'h0, 16'h00FF, 1'b0, 1'b0);   // back to back read
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 100000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule